// File: doc/BRIEF.md
# Exception and Control-Register Unit

This unit keeps the control registers of a 32-bit RISC core and carries out the change-of-flow work for software traps, breaks and the two matching return operations. Each cycle the decode stage hands it one operation code, together with the program counter of that operation, a value read from a general-purpose register and a 5-bit control-register index. One cycle later the unit presents three things. The first is the program counter that fetch should use next. The second is a flag that tells fetch to take that value in place of its own sequential address. The third is a writeback to the general-purpose register file: either the control-register value that was read, or a return address that trap or break entry saves.

Trap entry and break entry each copy the status register into a shadow register of their own. Both entries clear the two low status bits and record the address after the entering operation. Each return restores status from its own shadow and resumes at its own saved address. The unit keeps its own copies of the two saved return addresses. The writeback port publishes those same values so that the register file stays in step. The two handler entry addresses are parameters.

Top module: `excp_ctl_unit`

## Requirements
- R1: After reset every control register and both saved return addresses are zero, and `redirect` and `wb_valid` are low.
- R2: Operation code 1 (control read) gives, one cycle later, `wb_valid` high, `wb_kind` 0 (destination register) and `wb_data` equal to the selected control register as it stood before the operation. It gives no redirect.
- R3: Operation code 2 (control write) stores `src_val` into the control register selected by `ctl_idx`, and a later read of that index returns it. This also holds at the highest mapped index, NUM_CTL-1.
- R4: An index at or above NUM_CTL is unmapped. A write to it changes no register, and a read of it returns zero.
- R5: Operation code 3 (trap) copies status (index 0) into exception status (index 1). It clears status bits 1 and 0 and leaves every other status bit unchanged.
- R6: A trap records `pc_in`+4 as the exception return address. One cycle later it gives `redirect` high, `next_pc` equal to the exception handler address, `wb_valid` high, `wb_kind` 1 and `wb_data` equal to `pc_in`+4.
- R7: Operation code 4 (break) copies status into break status (index 2) and clears status bits 1 and 0. It records `pc_in`+4 as the break return address. One cycle later it gives `redirect` high, `next_pc` equal to the break handler address, `wb_kind` 2 and `wb_data` equal to `pc_in`+4.
- R8: Operation code 5 (exception return) copies exception status into status. One cycle later it gives `redirect` high with `next_pc` equal to the saved exception return address.
- R9: Operation code 6 (break return) copies break status into status. One cycle later it gives `redirect` high with `next_pc` equal to the saved break return address.
- R10: `redirect` is high only in the cycle that follows a trap, break or one of the two returns. After any other code (0, 1, 2, 7) it is low and `next_pc` equals that operation's `pc_in`+4.
- R11: The two shadows are independent. A break leaves exception status and the exception return address untouched, and a trap leaves break status and the break return address untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Decoded operation: 0 none, 1 read, 2 write, 3 trap, 4 break, 5 exception return, 6 break return, 7 none |
| pc_in | input | 32 | Program counter of the operation |
| src_val | input | 32 | General-purpose source value for a control write |
| ctl_idx | input | 5 | Control-register index |
| next_pc | output | 32 | Program counter fetch should use next |
| redirect | output | 1 | High when `next_pc` is a taken change of flow |
| wb_valid | output | 1 | General-purpose writeback present |
| wb_kind | output | 2 | Writeback target: 0 destination, 1 exception return address, 2 break return address |
| wb_data | output | 32 | Writeback value |

## Verification
The assertions watch every cycle for the register-level effects of each event. They check that a trap or break saves status into its own shadow and clears only the two low status bits. They check that each return restores status from the matching shadow, and that an unmapped write disturbs none of the status registers. They also check that the shadow of the other kind is left alone, that handler targets and return targets appear on `next_pc`, and that no redirect follows a non-flow operation. Only the bench scenarios show the end-to-end effects. These include a control-register value seen through a later read, the exact cleared status read back after entry, and a nested trap then break unwinding in the right order to the two different saved addresses.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned OP_W     = 3;
  localparam int unsigned KIND_W   = 2;
  localparam int unsigned MASK_LOW = 2;

  localparam int unsigned SLOT_STATUS  = 0;
  localparam int unsigned SLOT_ESTATUS = 1;
  localparam int unsigned SLOT_BSTATUS = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 3'd0,
    OP_CTL_RD = 3'd1,
    OP_CTL_WR = 3'd2,
    OP_TRAP   = 3'd3,
    OP_BRK    = 3'd4,
    OP_ERET   = 3'd5,
    OP_BRET   = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [KIND_W-1:0] {
    WB_DEST  = 2'd0,
    WB_EADDR = 2'd1,
    WB_BADDR = 2'd2,
    WB_SPARE = 2'd3
  } wb_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic trap;
    logic brk;
    logic eret;
    logic bret;
  } ev_t;

  // address of the operation after the current one
  function automatic word_t f_seq_pc(input word_t pc);
    return pc + word_t'(4);
  endfunction

  // status value after trap or break entry: low bits cleared
  function automatic word_t f_entry_mask(input word_t st);
    return st & ~word_t'((1 << MASK_LOW) - 1);
  endfunction
endpackage

// File: rtl/excp_decode.sv
module excp_decode
  import excp_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output ev_t             ev
);
  always_comb begin
    ev = '0;
    case (op_e'(op_code))
      OP_CTL_RD: ev.rd   = 1'b1;
      OP_CTL_WR: ev.wr   = 1'b1;
      OP_TRAP:   ev.trap = 1'b1;
      OP_BRK:    ev.brk  = 1'b1;
      OP_ERET:   ev.eret = 1'b1;
      OP_BRET:   ev.bret = 1'b1;
      default:   ev      = '0;
    endcase
  end
endmodule

// File: rtl/excp_ctl_bank.sv
module excp_ctl_bank
  import excp_pkg::*;
#(
  parameter int unsigned NUM_CTL = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  ev_t              ev,
  input  logic [IDX_W-1:0] idx,
  input  word_t            src,
  input  word_t            pc,
  output word_t            rd_data,
  output word_t            eaddr,
  output word_t            baddr
);
  word_t ctl_q [NUM_CTL];
  word_t eaddr_q;
  word_t baddr_q;

  // named views for the checks below
  word_t status, estatus, bstatus;
  logic  idx_mapped;

  assign status     = ctl_q[SLOT_STATUS];
  assign estatus    = ctl_q[SLOT_ESTATUS];
  assign bstatus    = ctl_q[SLOT_BSTATUS];
  assign idx_mapped = (32'(idx) < NUM_CTL);
  assign eaddr      = eaddr_q;
  assign baddr      = baddr_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTL; i++) begin
      if (idx == IDX_W'(i)) rd_data = ctl_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTL; i++) ctl_q[i] <= '0;
      eaddr_q <= '0;
      baddr_q <= '0;
    end else begin
      if (ev.wr) begin
        for (int i = 0; i < NUM_CTL; i++) begin
          if (idx == IDX_W'(i)) ctl_q[i] <= src;
        end
      end
      if (ev.trap) begin
        ctl_q[SLOT_ESTATUS] <= ctl_q[SLOT_STATUS];
        ctl_q[SLOT_STATUS]  <= f_entry_mask(ctl_q[SLOT_STATUS]);
        eaddr_q             <= f_seq_pc(pc);
      end
      if (ev.brk) begin
        ctl_q[SLOT_BSTATUS] <= ctl_q[SLOT_STATUS];
        ctl_q[SLOT_STATUS]  <= f_entry_mask(ctl_q[SLOT_STATUS]);
        baddr_q             <= f_seq_pc(pc);
      end
      if (ev.eret) ctl_q[SLOT_STATUS] <= ctl_q[SLOT_ESTATUS];
      if (ev.bret) ctl_q[SLOT_STATUS] <= ctl_q[SLOT_BSTATUS];
    end
  end

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.wr && !idx_mapped) |=> ($stable(status) && $stable(estatus) && $stable(bstatus))); // R4
  AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.trap |=> (estatus == $past(status))); // R5
  AST_TRAP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ev.trap |=> (status[MASK_LOW-1:0] == '0 &&
                 status[WORD_W-1:MASK_LOW] == $past(status[WORD_W-1:MASK_LOW]))); // R5
  AST_BRK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.brk |=> (bstatus == $past(status) && status[MASK_LOW-1:0] == '0)); // R7
  AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.eret |=> (status == $past(estatus))); // R8
  AST_BRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.bret |=> (status == $past(bstatus))); // R9
  AST_BRK_KEEPS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    ev.brk |=> ($stable(estatus) && $stable(eaddr_q))); // R11
  AST_TRAP_KEEPS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    ev.trap |=> ($stable(bstatus) && $stable(baddr_q))); // R11
endmodule

// File: rtl/excp_route.sv
module excp_route
  import excp_pkg::*;
#(
  parameter word_t EXC_VEC = 32'h0000_0020,
  parameter word_t BRK_VEC = 32'h0000_0100
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ev_t               ev,
  input  word_t             pc,
  input  word_t             rd_data,
  input  word_t             eaddr,
  input  word_t             baddr,
  output word_t             next_pc,
  output logic              redirect,
  output logic              wb_valid,
  output logic [KIND_W-1:0] wb_kind,
  output word_t             wb_data
);
  word_t    npc_d, wbd_d;
  logic     redir_d, wbv_d;
  wb_kind_e kind_d, kind_q;
  logic     flow_evt;

  assign flow_evt = ev.trap | ev.brk | ev.eret | ev.bret;

  always_comb begin
    npc_d   = f_seq_pc(pc);
    redir_d = 1'b0;
    wbv_d   = 1'b0;
    kind_d  = WB_DEST;
    wbd_d   = '0;
    if (ev.rd) begin
      wbv_d = 1'b1;
      wbd_d = rd_data;
    end
    if (ev.trap) begin
      redir_d = 1'b1;
      npc_d   = EXC_VEC;
      wbv_d   = 1'b1;
      kind_d  = WB_EADDR;
      wbd_d   = f_seq_pc(pc);
    end
    if (ev.brk) begin
      redir_d = 1'b1;
      npc_d   = BRK_VEC;
      wbv_d   = 1'b1;
      kind_d  = WB_BADDR;
      wbd_d   = f_seq_pc(pc);
    end
    if (ev.eret) begin
      redir_d = 1'b1;
      npc_d   = eaddr;
    end
    if (ev.bret) begin
      redir_d = 1'b1;
      npc_d   = baddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc  <= '0;
      redirect <= 1'b0;
      wb_valid <= 1'b0;
      kind_q   <= WB_DEST;
      wb_data  <= '0;
    end else begin
      next_pc  <= npc_d;
      redirect <= redir_d;
      wb_valid <= wbv_d;
      kind_q   <= kind_d;
      wb_data  <= wbd_d;
    end
  end

  assign wb_kind = kind_q;

  AST_RD_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rd |=> (wb_valid && !redirect && wb_kind == WB_DEST)); // R2
  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev.trap |=> (redirect && next_pc == EXC_VEC && wb_kind == WB_EADDR && wb_data == eaddr)); // R6
  AST_BRK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev.brk |=> (redirect && next_pc == BRK_VEC && wb_kind == WB_BADDR && wb_data == baddr)); // R7
  AST_ERET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev.eret |=> (redirect && next_pc == $past(eaddr))); // R8
  AST_BRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev.bret |=> (redirect && next_pc == $past(baddr))); // R9
  AST_REDIRECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_evt |=> !redirect); // R10
endmodule

// File: rtl/excp_ctl_unit.sv
module excp_ctl_unit
  import excp_pkg::*;
#(
  parameter int unsigned NUM_CTL = 8,
  parameter logic [31:0] EXC_VEC = 32'h0000_0020,
  parameter logic [31:0] BRK_VEC = 32'h0000_0100
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_code,
  input  logic [31:0] pc_in,
  input  logic [31:0] src_val,
  input  logic [4:0]  ctl_idx,
  output logic [31:0] next_pc,
  output logic        redirect,
  output logic        wb_valid,
  output logic [1:0]  wb_kind,
  output logic [31:0] wb_data
);
  ev_t   ev;
  word_t rd_data, eaddr, baddr;

  excp_decode u_decode (
    .op_code (op_code),
    .ev      (ev)
  );

  excp_ctl_bank #(.NUM_CTL(NUM_CTL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .idx     (ctl_idx),
    .src     (src_val),
    .pc      (pc_in),
    .rd_data (rd_data),
    .eaddr   (eaddr),
    .baddr   (baddr)
  );

  excp_route #(.EXC_VEC(EXC_VEC), .BRK_VEC(BRK_VEC)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .pc       (pc_in),
    .rd_data  (rd_data),
    .eaddr    (eaddr),
    .baddr    (baddr),
    .next_pc  (next_pc),
    .redirect (redirect),
    .wb_valid (wb_valid),
    .wb_kind  (wb_kind),
    .wb_data  (wb_data)
  );
endmodule

// File: tb/excp_ctl_unit_bench.sv
module excp_ctl_unit_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] T_EXC      = 32'h0000_0180;
  localparam logic [31:0] T_BRK      = 32'h0000_0240;
  localparam int          T_NCTL     = 8;

  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_TRAP = 3'd3,
                         C_BRK = 3'd4, C_ERET = 3'd5, C_BRET = 3'd6, C_RSVD = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] pc_in = '0, src_val = '0;
  logic [4:0]  ctl_idx = '0;
  logic [31:0] next_pc, wb_data;
  logic        redirect, wb_valid;
  logic [1:0]  wb_kind;

  int n_chk = 0;
  int n_fail = 0;

  excp_ctl_unit #(.NUM_CTL(T_NCTL), .EXC_VEC(T_EXC), .BRK_VEC(T_BRK)) u_excp_ctl_unit (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .pc_in(pc_in), .src_val(src_val),
    .ctl_idx(ctl_idx), .next_pc(next_pc), .redirect(redirect), .wb_valid(wb_valid),
    .wb_kind(wb_kind), .wb_data(wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one operation, wait until its result is on the outputs
  task automatic step(input logic [2:0] op, input logic [31:0] pc,
                      input logic [4:0] idx, input logic [31:0] src);
    op_code = op; pc_in = pc; ctl_idx = idx; src_val = src;
    @(negedge clk);
  endtask

  task automatic read_ctl(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    step(C_RD, 32'h0000_0900, idx, '0);
    chk({tag, " rd valid"}, 32'(wb_valid), 32'd1);
    chk({tag, " rd kind"}, 32'(wb_kind), 32'd0);
    chk({tag, " rd data"}, wb_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 redirect", 32'(redirect), 32'd0);
    chk("R1 wb_valid", 32'(wb_valid), 32'd0);
    read_ctl("R1 status", 5'd0, 32'h0);
    read_ctl("R1 estatus", 5'd1, 32'h0);
    read_ctl("R1 bstatus", 5'd2, 32'h0);
    step(C_ERET, 32'h0000_0010, '0, '0);
    chk("R1 eret to zero addr", next_pc, 32'h0);
  endtask

  task automatic t_rdwr;
    step(C_WR, 32'h0000_0040, 5'd3, 32'hDEAD_BEEF);
    chk("R10 wr no redirect", 32'(redirect), 32'd0);
    chk("R10 wr no wb", 32'(wb_valid), 32'd0);
    chk("R10 wr seq pc", next_pc, 32'h0000_0044);
    step(C_RD, 32'h0000_0048, 5'd3, '0);
    chk("R2 rd redirect", 32'(redirect), 32'd0);
    chk("R2 rd seq pc", next_pc, 32'h0000_004C);
    chk("R3 rd data", wb_data, 32'hDEAD_BEEF);
    step(C_WR, 32'h0, 5'(T_NCTL-1), 32'h0000_0077);
    read_ctl("R3 top index", 5'(T_NCTL-1), 32'h0000_0077);
  endtask

  task automatic t_unmapped;
    step(C_WR, 32'h0, 5'd17, 32'h1234_5678);
    read_ctl("R4 unmapped", 5'd17, 32'h0);
    step(C_WR, 32'h0, 5'(T_NCTL), 32'hFFFF_FFFF);
    read_ctl("R4 first unmapped", 5'(T_NCTL), 32'h0);
    read_ctl("R4 status kept", 5'd0, 32'h0);
  endtask

  task automatic t_trap;
    step(C_WR, 32'h0, 5'd0, 32'hA5A5_A5A7);
    step(C_TRAP, 32'h0000_1000, '0, '0);
    chk("R6 redirect", 32'(redirect), 32'd1);
    chk("R6 target", next_pc, T_EXC);
    chk("R6 wb valid", 32'(wb_valid), 32'd1);
    chk("R6 wb kind", 32'(wb_kind), 32'd1);
    chk("R6 wb data", wb_data, 32'h0000_1004);
    step(C_NONE, 32'h0000_0180, '0, '0);
    chk("R10 one cycle", 32'(redirect), 32'd0);
    chk("R10 idle seq pc", next_pc, 32'h0000_0184);
    read_ctl("R5 status masked", 5'd0, 32'hA5A5_A5A4);
    read_ctl("R5 estatus saved", 5'd1, 32'hA5A5_A5A7);
  endtask

  task automatic t_break;
    step(C_WR, 32'h0, 5'd0, 32'hF0F0_0003);
    step(C_BRK, 32'h0000_3000, '0, '0);
    chk("R7 redirect", 32'(redirect), 32'd1);
    chk("R7 target", next_pc, T_BRK);
    chk("R7 wb kind", 32'(wb_kind), 32'd2);
    chk("R7 wb data", wb_data, 32'h0000_3004);
    read_ctl("R7 status masked", 5'd0, 32'hF0F0_0000);
    read_ctl("R7 bstatus saved", 5'd2, 32'hF0F0_0003);
    read_ctl("R11 estatus kept", 5'd1, 32'hA5A5_A5A7);
  endtask

  task automatic t_returns;
    step(C_BRET, 32'h0000_5000, '0, '0);
    chk("R9 redirect", 32'(redirect), 32'd1);
    chk("R9 target", next_pc, 32'h0000_3004);
    read_ctl("R9 status", 5'd0, 32'hF0F0_0003);
    step(C_ERET, 32'h0000_6000, '0, '0);
    chk("R8 redirect", 32'(redirect), 32'd1);
    chk("R8 target", next_pc, 32'h0000_1004);
    read_ctl("R8 status", 5'd0, 32'hA5A5_A5A7);
  endtask

  task automatic t_other_ops;
    step(C_RSVD, 32'h0000_0A00, 5'd1, 32'h5555_5555);
    chk("R10 code7 redirect", 32'(redirect), 32'd0);
    chk("R10 code7 wb", 32'(wb_valid), 32'd0);
    chk("R10 code7 seq pc", next_pc, 32'h0000_0A04);
    step(C_NONE, 32'h0000_0B00, '0, '0);
    chk("R10 code0 redirect", 32'(redirect), 32'd0);
    chk("R10 code0 seq pc", next_pc, 32'h0000_0B04);
    read_ctl("R10 code7 no write", 5'd1, 32'hA5A5_A5A7);
  endtask

  task automatic t_nested;
    step(C_TRAP, 32'h0000_7000, '0, '0);
    chk("R11 nested trap target", next_pc, T_EXC);
    step(C_BRK, 32'h0000_8000, '0, '0);
    chk("R11 nested brk target", next_pc, T_BRK);
    read_ctl("R11 nested estatus", 5'd1, 32'hA5A5_A5A7);
    read_ctl("R11 nested bstatus", 5'd2, 32'hA5A5_A5A4);
    step(C_BRET, 32'h0000_0300, '0, '0);
    chk("R11 nested bret", next_pc, 32'h0000_8004);
    read_ctl("R11 status after bret", 5'd0, 32'hA5A5_A5A4);
    step(C_ERET, 32'h0000_0400, '0, '0);
    chk("R11 nested eret", next_pc, 32'h0000_7004);
    read_ctl("R11 status after eret", 5'd0, 32'hA5A5_A5A7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step(C_NONE, 32'h0000_0000, '0, '0);
    t_reset();
    t_rdwr();
    t_unmapped();
    t_trap();
    t_break();
    t_returns();
    t_other_ops();
    t_nested();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired got=%0d exp=%0d", 5000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule